// File: doc/BRIEF.md
# Nibble-Merge Background RAM Writer

This block owns the write side of an 8-bit background RAM. The processor can only supply four bits per store. A display/DMA reader normally owns the RAM address. When the processor stores into the background window, the block takes the RAM away from the reader. It reads the addressed byte and latches that old byte in a holding register. One clock later it pulses the RAM write enable with a merged byte: the new nibble in the chosen half and the old nibble in the other half.

The processor's low six address lines reach the block inverted, so the block inverts them back before they address the RAM. A window address bit above the RAM index picks the upper or lower half. A store that arrives while a merge is still running is stalled with a wait signal until the sequencer is free. The synchronous single-port RAM sits inside the block, and the reader sees its registered output.

Top module: `bgw_top`

## Requirements
- R1: Only writes with `cpu_addr` in 0xC000..0xCFFF are acted on. A write outside that range leaves every RAM byte unchanged and never raises `cpu_wait`.
- R2: `dma_grant` goes low in the same cycle that an in-window `cpu_wr` is presented. It stays low until the merge sequence ends. Otherwise it is high, and the RAM is then addressed by `dma_addr`.
- R3: With window bit 11 set, bits [7:4] of the addressed byte become `cpu_nib`. With it clear, bits [3:0] become `cpu_nib`. The other nibble keeps its previous value.
- R4: After the edge that accepts a write, the sequence runs through a read cycle, then a latch cycle, then a write cycle. `bg_we` is high only in that write cycle, the third cycle after acceptance, for exactly one cycle.
- R5: The RAM byte index is `cpu_addr[10:0]` with bits [5:0] inverted and bits [10:6] passed straight through.
- R6: An in-window write presented while a sequence is busy raises `cpu_wait`. It is accepted at the first idle cycle and lands after the earlier write.
- R7: Reset puts the sequencer in idle, with `bg_we` low, `dma_grant` high and `cpu_wait` low. A reset in the middle of a sequence abandons that write.
- R8: While granted, `dma_rdata` shows the byte at `dma_addr`, registered one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address, low six bits inverted |
| cpu_nib | input | 4 | Nibble to store |
| cpu_wr | input | 1 | Write strobe, held until `cpu_wait` is low |
| cpu_wait | output | 1 | Stall: an in-window write must be held |
| dma_addr | input | 11 | Reader byte address |
| dma_grant | output | 1 | Reader owns the RAM address |
| dma_rdata | output | 8 | Registered RAM read data |
| bg_we | output | 1 | RAM write enable of the merge sequence |

## Verification
Two functions can fall in the same cycle. A new in-window store can arrive while a previous merge is still in its latch or write step, and the reader's fetch and the processor's takeover can coincide. The bench provokes the first with two stores issued back to back, with no gap between them, to the two halves of one byte. It judges the result by the stall indication and by the final byte, which must carry both nibbles. It provokes the second by presenting a store while the reader is active. Grant must fall in that same cycle and return only after the write pulse.

// File: rtl/bgw_pkg.sv
package bgw_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_LATCH = 2'd2,
        SEQ_WRITE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             hi;
        logic [NIB_W-1:0] nib;
    } nib_req_t;

    function automatic logic [BYTE_W-1:0] merge_nibble(
        input logic [BYTE_W-1:0] old_b,
        input nib_req_t          req
    );
        return req.hi ? {req.nib, old_b[NIB_W-1:0]}
                      : {old_b[BYTE_W-1:NIB_W], req.nib};
    endfunction

    function automatic seq_state_e seq_next(input seq_state_e cur, input logic start);
        case (cur)
            SEQ_IDLE:  return start ? SEQ_READ : SEQ_IDLE;
            SEQ_READ:  return SEQ_LATCH;
            SEQ_LATCH: return SEQ_WRITE;
            default:   return SEQ_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/bgw_win_decode.sv
module bgw_win_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BASE = 'hC000,
    parameter int RAM_AW   = 11,
    parameter int INV_BITS = 6
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    output logic              hit,
    output logic [RAM_AW-1:0] idx,
    output logic              hi_sel
);
    localparam int WIN_LOG2 = RAM_AW + 1;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

    assign hit    = cpu_wr && (cpu_addr[ADDR_W-1:WIN_LOG2] == BASE_V[ADDR_W-1:WIN_LOG2]);
    assign hi_sel = cpu_addr[RAM_AW];

    for (genvar i = 0; i < RAM_AW; i++) begin : g_bit
        if (i < INV_BITS) begin : g_inv
            assign idx[i] = ~cpu_addr[i];
        end else begin : g_pass
            assign idx[i] = cpu_addr[i];
        end
    end
endmodule

// File: rtl/bgw_addr_mux.sv
module bgw_addr_mux #(
    parameter int RAM_AW = 11
) (
    input  logic              live_hit,
    input  logic [RAM_AW-1:0] live_idx,
    input  logic              busy,
    input  logic [RAM_AW-1:0] req_idx,
    input  logic [RAM_AW-1:0] dma_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              dma_grant
);
    always_comb begin
        if (busy)          ram_addr = req_idx;
        else if (live_hit) ram_addr = live_idx;
        else               ram_addr = dma_addr;
    end

    assign dma_grant = !(busy || live_hit);
endmodule

// File: rtl/bgw_merge_seq.sv
module bgw_merge_seq
    import bgw_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [RAM_AW-1:0] idx,
    input  logic              hi_sel,
    input  logic [NIB_W-1:0]  nib,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic              busy,
    output logic              cpu_wait,
    output logic [RAM_AW-1:0] req_idx,
    output logic              ram_we,
    output logic [BYTE_W-1:0] ram_wdata
);
    seq_state_e        state_q;
    nib_req_t          req_q;
    logic [BYTE_W-1:0] hold_q;
    logic              we_q;
    logic              start;

    assign busy     = (state_q != SEQ_IDLE);
    assign start    = hit && !busy;
    assign cpu_wait = hit && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            we_q    <= 1'b0;
        end else begin
            state_q <= seq_next(state_q, start);
            we_q    <= (state_q == SEQ_LATCH);
        end
    end

    always_ff @(posedge clk) begin
        if (start) begin
            req_idx <= idx;
            req_q   <= '{hi: hi_sel, nib: nib};
        end
        if (state_q == SEQ_LATCH) begin
            hold_q <= ram_rdata;
        end
    end

    assign ram_we    = we_q;
    assign ram_wdata = merge_nibble(hold_q, req_q);
endmodule

// File: rtl/bgw_ram.sv
module bgw_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/bgw_top.sv
module bgw_top
    import bgw_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BASE = 'hC000,
    parameter int RAM_AW   = 11,
    parameter int INV_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [NIB_W-1:0]  cpu_nib,
    input  logic              cpu_wr,
    output logic              cpu_wait,
    input  logic [RAM_AW-1:0] dma_addr,
    output logic              dma_grant,
    output logic [BYTE_W-1:0] dma_rdata,
    output logic              bg_we
);
    logic              cpu_hit;
    logic [RAM_AW-1:0] live_idx;
    logic              live_hi;
    logic              seq_busy;
    logic [RAM_AW-1:0] req_idx;
    logic [RAM_AW-1:0] ram_addr;
    logic [BYTE_W-1:0] ram_wdata;
    logic [BYTE_W-1:0] ram_rdata;

    bgw_win_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .RAM_AW(RAM_AW), .INV_BITS(INV_BITS)
    ) u_dec (
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .hit(cpu_hit), .idx(live_idx), .hi_sel(live_hi)
    );

    bgw_merge_seq #(.RAM_AW(RAM_AW)) u_seq (
        .clk(clk), .rst(rst),
        .hit(cpu_hit), .idx(live_idx), .hi_sel(live_hi), .nib(cpu_nib),
        .ram_rdata(ram_rdata),
        .busy(seq_busy), .cpu_wait(cpu_wait), .req_idx(req_idx),
        .ram_we(bg_we), .ram_wdata(ram_wdata)
    );

    bgw_addr_mux #(.RAM_AW(RAM_AW)) u_mux (
        .live_hit(cpu_hit), .live_idx(live_idx),
        .busy(seq_busy), .req_idx(req_idx),
        .dma_addr(dma_addr),
        .ram_addr(ram_addr), .dma_grant(dma_grant)
    );

    bgw_ram #(.AW(RAM_AW), .DW(BYTE_W)) u_ram (
        .clk(clk), .we(bg_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    assign dma_rdata = ram_rdata;
endmodule

// File: rtl/bgw_chk.sv
module bgw_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_wr,
    input logic          cpu_hit,
    input logic          busy,
    input logic          bg_we,
    input logic          dma_grant,
    input logic [AW-1:0] ram_addr,
    input logic          cpu_wait
);
    // R2
    we_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        bg_we |-> !dma_grant);

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        bg_we |=> !bg_we);

    // R4
    we_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        bg_we |-> $stable(ram_addr));

    // R6
    wait_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wait |-> busy);

    // R1
    outside_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_hit && !busy) |=> !busy);

    // R7
    post_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bg_we && !busy));
endmodule

bind bgw_top bgw_chk u_chk (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_hit(cpu_hit),
    .busy(seq_busy), .bg_we(bg_we), .dma_grant(dma_grant),
    .ram_addr(ram_addr), .cpu_wait(cpu_wait)
);

// File: tb/sim_bgw_top.sv
module sim_bgw_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [3:0]  cpu_nib = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_wait;
    logic [10:0] dma_addr = '0;
    logic        dma_grant;
    logic [7:0]  dma_rdata;
    logic        bg_we;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    bgw_top u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_nib(cpu_nib),
        .cpu_wr(cpu_wr), .cpu_wait(cpu_wait), .dma_addr(dma_addr),
        .dma_grant(dma_grant), .dma_rdata(dma_rdata), .bg_we(bg_we)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [3:0]  d;
        logic        chk;
        logic [10:0] idx;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{16'hC03F, 4'h5, 1'b0, 11'h000, 8'h00},
        '{16'hC83F, 4'hA, 1'b1, 11'h000, 8'hA5},
        '{16'hC03F, 4'h3, 1'b1, 11'h000, 8'hA3},
        '{16'hC7FE, 4'h7, 1'b0, 11'h7C1, 8'h00},
        '{16'hCFFE, 4'hC, 1'b1, 11'h7C1, 8'hC7},
        '{16'hCFFE, 4'h1, 1'b1, 11'h7C1, 8'h17},
        '{16'hC015, 4'h9, 1'b0, 11'h02A, 8'h00},
        '{16'hC815, 4'h6, 1'b1, 11'h02A, 8'h69},
        '{16'hD015, 4'h0, 1'b1, 11'h02A, 8'h69},
        '{16'hB83F, 4'h0, 1'b1, 11'h000, 8'hA3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // caller sits at a negedge; returns at a negedge with cpu_wr low
    task automatic cpu_write(input logic [15:0] a, input logic [3:0] d, output bit saw_wait);
        saw_wait = 0;
        cpu_addr = a;
        cpu_nib  = d;
        cpu_wr   = 1'b1;
        #1;
        while (cpu_wait) begin
            saw_wait = 1;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic dma_read(input logic [10:0] a, output logic [7:0] v);
        dma_addr = a;
        @(posedge clk);
        @(negedge clk);
        v = dma_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        bit w;

        repeat (3) @(negedge clk);
        // R7 reset state
        check(dma_grant == 1'b1, "R7 grant in reset", dma_grant, 1);
        check(bg_we == 1'b0, "R7 we in reset", bg_we, 0);
        check(cpu_wait == 1'b0, "R7 wait in reset", cpu_wait, 0);
        rst = 1'b0;
        @(negedge clk);
        check(dma_grant == 1'b1 && bg_we == 1'b0, "R7 idle after reset", {dma_grant, bg_we}, 2);

        // vector table: R3 R5 nibble merge / address restore, R1 outside window
        for (int i = 0; i < 10; i++) begin
            cpu_write(VECS[i].a, VECS[i].d, w);
            if (i >= 8) check(w == 1'b0, "R1 no stall outside window", w, 0);
            settle();
            if (VECS[i].chk) begin
                dma_read(VECS[i].idx, rd);
                if (i >= 8) check(rd == VECS[i].exp, "R1 outside write ignored", rd, VECS[i].exp);
                else        check(rd == VECS[i].exp, "R3 R5 merged byte", rd, VECS[i].exp);
            end
        end

        // R8 reader path
        dma_read(11'h7C1, rd);
        check(rd == 8'h17, "R8 dma read data", rd, 8'h17);

        // R2 R4 cycle timing of one write
        cpu_addr = 16'hC015; cpu_nib = 4'h2; cpu_wr = 1'b1;
        #1;
        check(dma_grant == 1'b0, "R2 grant drops with strobe", dma_grant, 0);
        @(posedge clk); @(negedge clk); cpu_wr = 1'b0;
        check(bg_we == 1'b0, "R4 we low in read cycle", bg_we, 0);
        check(dma_grant == 1'b0, "R2 grant low while busy", dma_grant, 0);
        @(posedge clk); @(negedge clk);
        check(bg_we == 1'b0, "R4 we low in latch cycle", bg_we, 0);
        @(posedge clk); @(negedge clk);
        check(bg_we == 1'b1, "R4 we high in write cycle", bg_we, 1);
        check(dma_grant == 1'b0, "R2 grant low in write cycle", dma_grant, 0);
        @(posedge clk); @(negedge clk);
        check(bg_we == 1'b0, "R4 we single cycle", bg_we, 0);
        check(dma_grant == 1'b1, "R2 grant returns", dma_grant, 1);
        dma_read(11'h02A, rd);
        check(rd == 8'h62, "R3 lower nibble write", rd, 8'h62);

        // R6 back-to-back writes to both halves of byte 0
        cpu_write(16'hC83F, 4'hE, w);
        cpu_write(16'hC03F, 4'h1, w);
        check(w == 1'b1, "R6 second write stalled", w, 1);
        settle();
        dma_read(11'h000, rd);
        check(rd == 8'hE1, "R6 both held writes applied", rd, 8'hE1);

        // R7 reset mid-sequence abandons the write
        cpu_addr = 16'hC815; cpu_nib = 4'hF; cpu_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(dma_grant == 1'b1 && bg_we == 1'b0, "R7 reset mid sequence", {dma_grant, bg_we}, 2);
        @(posedge clk); @(negedge clk);
        check(bg_we == 1'b0, "R7 no write after reset", bg_we, 0);
        rst = 1'b0;
        settle();
        dma_read(11'h02A, rd);
        check(rd == 8'h62, "R7 aborted write left byte", rd, 8'h62);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule